// File: doc/BRIEF.md
# DDR Interleaved I/Q Receive Port

This block is the receive side of a double-data-rate parallel link that carries two converter channels on one 16-bit bus. The source sends a new word on every edge of the sampling clock, alternating between the in-phase (I) and quadrature (Q) channel. A seventeenth line, the companion strobe, runs beside the data with an alternating 1/0 pattern at the sampling-clock rate, and its level marks each word: high for I, low for Q. The block captures each word together with its strobe level on both clock edges. It joins each I word to the Q word that follows it and presents one I/Q pair per cycle on a valid/ready output. The sampling clock is also forwarded back to the source.

The analog delay lines used for link calibration are modelled as tap indices counted in half-periods of the sampling clock. The data tap delays the word stream by whole half-periods. The setup and hold taps together place a probe that samples the delayed strobe once per cycle. The registered probe value is a readable status bit. A change flag pulses whenever that bit differs from its previous sample, which shows that the probe sits on a strobe transition or that the alternating pattern is broken.

Output rules: a pair is offered with `iq_valid` high. It is held unchanged, with `iq_valid` high, until a cycle in which `iq_ready` is also high. The incoming stream cannot be stalled, so any pair completed while the output is held is discarded.

Top module: `iqp_ddr_rx`

## Requirements
- R1: While `rst_n` is low, `iq_valid`, `seek` and `seek_err` are 0 and the capture history is cleared to all-zero words with a low strobe.
- R2: A word and its strobe level are captured on every rising edge and every falling edge of `clk`. The rising-edge word comes first in stream order and the falling-edge word follows it.
- R3: A word captured with the strobe high is an I word and one captured low is a Q word. A Q word that follows a pending I word completes a pair, reported as `i_data` = the I word and `q_data` = the Q word.
- R4: A Q word with no pending I word is dropped. An I word that arrives while another I word is pending replaces it.
- R5: Counting half-samples by age, where age 0 is the falling-edge word latched before the previous rising edge, each rising edge steers the word of age `smp_tap`+1 and then the word of age `smp_tap`. The output register updates on that same edge.
- R6: While `iq_valid` is high and `iq_ready` is low, `iq_valid`, `i_data` and `q_data` hold. Pairs completed in those cycles are discarded. With `iq_ready` high, a completed pair is loaded, and `iq_valid` falls in a cycle that completes no pair.
- R7: On each rising edge `seek` loads the strobe level of the half-sample of age 31 + `setup_tap` − `hold_tap`. Raising `hold_tap` moves the probe one half-period later in time, and raising `setup_tap` moves it one half-period earlier. With the alternating pattern and equal taps, `seek` stays 1.
- R8: `seek_err` is high for exactly the cycles in which the new `seek` value differs from the previous one. It is never high on the first probe after reset.
- R9: `dclk_out` follows `clk`: high after each rising edge and low after each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; data captured on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | DDR data word |
| dci_in | input | 1 | Companion strobe; high marks I, low marks Q |
| smp_tap | input | 5 | Data delay in half-periods |
| setup_tap | input | 5 | Probe setup delay, moves sample earlier |
| hold_tap | input | 5 | Probe hold delay, moves sample later |
| dclk_out | output | 1 | Clock forwarded to the source |
| i_data | output | 16 | I word of the offered pair |
| q_data | output | 16 | Q word of the offered pair |
| iq_valid | output | 1 | Pair offered |
| iq_ready | input | 1 | Consumer accepts the offered pair |
| seek | output | 1 | Registered probe sample of the delayed strobe |
| seek_err | output | 1 | Pulse when `seek` changed from its previous sample |

## Verification
The hardest condition to reach from the ports is a `seek_err` pulse while the taps are held still. It needs a break in the strobe's alternation, and that break has to travel through the history until it lands on the half-sample age the probe selects. The stimulus sends one rising-edge word with its strobe low inside an otherwise clean stream. It then keeps the taps fixed while the bad half-sample moves through the history. The reference model tracks the same ages, so it predicts the two pulses, one as the probe lands on the bad half-sample and one as it leaves. Separate tap sweeps change `setup_tap` and `hold_tap` across both parities to move the probe between high and low half-samples.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

  // Probe age in half-samples: centre of the tap range, shifted by setup minus hold.
  function automatic int unsigned probe_age(input int unsigned tap_bits,
                                            input int unsigned setup_v,
                                            input int unsigned hold_v);
    int unsigned centre;
    centre = (1 << tap_bits) - 1;
    return centre + setup_v - hold_v;
  endfunction

endpackage

// File: rtl/iqp_ddr_capture.sv
module iqp_ddr_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          dci_in,
  output logic [DW:0]   rise_word,
  output logic [DW:0]   fall_word
);

  // Rising-edge lane
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_word <= '0;
    else        rise_word <= {dci_in, din};
  end

  // Falling-edge lane
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_word <= '0;
    else        fall_word <= {dci_in, din};
  end

endmodule

// File: rtl/iqp_tap_history.sv
module iqp_tap_history #(
  parameter int DW   = 16,
  parameter int TAPW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW:0]   rise_word,
  input  logic [DW:0]   fall_word,
  input  logic [TAPW-1:0] smp_tap,
  input  logic [TAPW:0] probe_sel,
  output logic [DW:0]   early_word,
  output logic [DW:0]   late_word,
  output logic          probe_bit
);

  localparam int NPAIR = 1 << TAPW;
  localparam int NHALF = 2 * NPAIR;

  logic [DW:0] rise_hist [NPAIR];
  logic [DW:0] fall_hist [NPAIR];
  logic [DW:0] halves    [NHALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NPAIR; j++) begin
        rise_hist[j] <= '0;
        fall_hist[j] <= '0;
      end
    end else begin
      rise_hist[0] <= rise_word;
      fall_hist[0] <= fall_word;
      for (int j = 1; j < NPAIR; j++) begin
        rise_hist[j] <= rise_hist[j-1];
        fall_hist[j] <= fall_hist[j-1];
      end
    end
  end

  // Age order: even ages are falling-edge words, odd ages the rising word before them.
  for (genvar g = 0; g < NPAIR; g++) begin : g_age
    assign halves[2*g]   = fall_hist[g];
    assign halves[2*g+1] = rise_hist[g];
  end

  logic [TAPW:0] late_idx;
  logic [TAPW:0] early_idx;
  assign late_idx  = {1'b0, smp_tap};
  assign early_idx = late_idx + 1'b1;

  assign late_word  = halves[late_idx];
  assign early_word = halves[early_idx];
  assign probe_bit  = halves[probe_sel][DW];

endmodule

// File: rtl/iqp_iq_steer.sv
module iqp_iq_steer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW:0]   early_word,
  input  logic [DW:0]   late_word,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);

  logic          pend_v;
  logic [DW-1:0] pend_i;

  logic          nxt_pend_v;
  logic [DW-1:0] nxt_pend_i;
  logic          got_pair;
  logic [DW-1:0] got_i;
  logic [DW-1:0] got_q;
  logic [DW:0]   words [2];

  assign words[0] = early_word;
  assign words[1] = late_word;

  always_comb begin
    nxt_pend_v = pend_v;
    nxt_pend_i = pend_i;
    got_pair   = 1'b0;
    got_i      = '0;
    got_q      = '0;
    for (int k = 0; k < 2; k++) begin
      if (words[k][DW]) begin
        nxt_pend_v = 1'b1;
        nxt_pend_i = words[k][DW-1:0];
      end else if (nxt_pend_v) begin
        got_pair   = 1'b1;
        got_i      = nxt_pend_i;
        got_q      = words[k][DW-1:0];
        nxt_pend_v = 1'b0;
      end
    end
  end

  logic hold_out;
  assign hold_out = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_i    <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      pend_v <= nxt_pend_v;
      pend_i <= nxt_pend_i;
      if (!hold_out) begin
        out_valid <= got_pair;
        if (got_pair) begin
          out_i <= got_i;
          out_q <= got_q;
        end
      end
    end
  end

endmodule

// File: rtl/iqp_seek_probe.sv
module iqp_seek_probe (
  input  logic clk,
  input  logic rst_n,
  input  logic probe_bit,
  output logic seek,
  output logic seek_err
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seek     <= 1'b0;
      seek_err <= 1'b0;
      primed   <= 1'b0;
    end else begin
      seek     <= probe_bit;
      seek_err <= primed && (probe_bit != seek);
      primed   <= 1'b1;
    end
  end

endmodule

// File: rtl/iqp_ddr_rx.sv
module iqp_ddr_rx #(
  parameter int DW   = 16,
  parameter int TAPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   din,
  input  logic            dci_in,
  input  logic [TAPW-1:0] smp_tap,
  input  logic [TAPW-1:0] setup_tap,
  input  logic [TAPW-1:0] hold_tap,
  output logic            dclk_out,
  output logic [DW-1:0]   i_data,
  output logic [DW-1:0]   q_data,
  output logic            iq_valid,
  input  logic            iq_ready,
  output logic            seek,
  output logic            seek_err
);

  import iqp_pkg::*;

  logic [DW:0]   rise_word;
  logic [DW:0]   fall_word;
  logic [DW:0]   early_word;
  logic [DW:0]   late_word;
  logic          probe_bit;
  logic [TAPW:0] probe_sel;

  assign dclk_out  = clk;
  assign probe_sel = TAPW'(0) + (TAPW+1)'(probe_age(TAPW, int'(setup_tap), int'(hold_tap)));

  iqp_ddr_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .dci_in    (dci_in),
    .rise_word (rise_word),
    .fall_word (fall_word)
  );

  iqp_tap_history #(.DW(DW), .TAPW(TAPW)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_word  (rise_word),
    .fall_word  (fall_word),
    .smp_tap    (smp_tap),
    .probe_sel  (probe_sel),
    .early_word (early_word),
    .late_word  (late_word),
    .probe_bit  (probe_bit)
  );

  iqp_iq_steer #(.DW(DW)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .early_word (early_word),
    .late_word  (late_word),
    .out_ready  (iq_ready),
    .out_valid  (iq_valid),
    .out_i      (i_data),
    .out_q      (q_data)
  );

  iqp_seek_probe u_probe (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_bit (probe_bit),
    .seek      (seek),
    .seek_err  (seek_err)
  );

endmodule

// File: rtl/iqp_ddr_rx_check.sv
module iqp_ddr_rx_check #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] i_data,
  input logic [DW-1:0] q_data,
  input logic          iq_valid,
  input logic          iq_ready,
  input logic          seek,
  input logic          seek_err
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!iq_valid && !seek && !seek_err); // R1
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid && !iq_ready |=> iq_valid); // R6

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid && !iq_ready |=> $stable(i_data) && $stable(q_data)); // R6

  AST_ERR_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seek_err |-> seek != $past(seek)); // R8

endmodule

bind iqp_ddr_rx iqp_ddr_rx_check #(.DW(DW)) u_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .i_data   (i_data),
  .q_data   (q_data),
  .iq_valid (iq_valid),
  .iq_ready (iq_ready),
  .seek     (seek),
  .seek_err (seek_err)
);

// File: tb/tb_iqp_ddr_rx.sv
`timescale 1ns/1ps
module tb_iqp_ddr_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = '0;
  logic        dci_in = 1'b0;
  logic [4:0]  smp_tap = '0;
  logic [4:0]  setup_tap = '0;
  logic [4:0]  hold_tap = '0;
  logic        iq_ready = 1'b1;
  logic        dclk_out;
  logic [15:0] i_data, q_data;
  logic        iq_valid, seek, seek_err;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  string tag = "R2";

  always #4 clk = ~clk;

  iqp_ddr_rx dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dci_in(dci_in),
    .smp_tap(smp_tap), .setup_tap(setup_tap), .hold_tap(hold_tap),
    .dclk_out(dclk_out), .i_data(i_data), .q_data(q_data),
    .iq_valid(iq_valid), .iq_ready(iq_ready), .seek(seek), .seek_err(seek_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: half-samples in capture order, newest at index 0
  logic [16:0] hq[$];
  logic        m_pv, m_v, m_seek, m_err, m_primed;
  logic [15:0] m_pi, m_i, m_q;

  initial for (int n = 0; n < 80; n++) hq.push_front(17'h0);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pv = 0; m_v = 0; m_seek = 0; m_err = 0; m_primed = 0;
    end else begin
      logic [16:0] w [2];
      logic        got;
      logic [15:0] gi, gq;
      int          d, a;
      d = int'(smp_tap);
      w[0] = hq[d + 3];
      w[1] = hq[d + 2];
      got = 0; gi = '0; gq = '0;
      for (int k = 0; k < 2; k++) begin
        if (w[k][16]) begin
          m_pv = 1; m_pi = w[k][15:0];
        end else if (m_pv) begin
          got = 1; gi = m_pi; gq = w[k][15:0]; m_pv = 0;
        end
      end
      if (!(m_v && !iq_ready)) begin
        m_v = got;
        if (got) begin m_i = gi; m_q = gq; end
      end
      a = 31 + int'(setup_tap) - int'(hold_tap);
      m_err = m_primed && (hq[a + 2][16] != m_seek);
      m_seek = hq[a + 2][16];
      m_primed = 1;
    end
    hq.push_front({dci_in, din});
    void'(hq.pop_back());
  end

  always @(negedge clk) begin
    hq.push_front({dci_in, din});
    void'(hq.pop_back());
  end

  // Compare on every cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      check({tag, "/R6 valid"}, 32'(iq_valid), 32'(m_v));
      if (m_v) begin
        check({tag, "/R3 i_data"}, 32'(i_data), 32'(m_i));
        check({tag, "/R3 q_data"}, 32'(q_data), 32'(m_q));
      end
      check("R7 seek", 32'(seek), 32'(m_seek));
      check("R8 seek_err", 32'(seek_err), 32'(m_err));
    end
  end

  task automatic send(input logic rd, input logic [15:0] rw,
                      input logic fd, input logic [15:0] fw);
    @(negedge clk); #1 dci_in = rd; din = rw;
    @(posedge clk); #1 dci_in = fd; din = fw;
  endtask

  task automatic send_clean(input int cycles, input int base);
    for (int n = 0; n < cycles; n++)
      send(1'b1, 16'(16'hA000 + base + n), 1'b0, 16'(16'h5000 + base + n));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1 valid", 32'(iq_valid), 0);
    check("R1 seek", 32'(seek), 0);
    check("R1 seek_err", 32'(seek_err), 0);
    @(negedge clk); #1 rst_n = 1'b1;
    cmp_on = 1;

    // R9: forwarded clock
    @(posedge clk); #2 check("R9 dclk high", 32'(dclk_out), 1);
    @(negedge clk); #2 check("R9 dclk low", 32'(dclk_out), 0);

    // R2: clean alternating stream, both edges
    tag = "R2";
    send_clean(40, 0);

    // R5: data tap delays
    tag = "R5";
    smp_tap = 5'd3;  send_clean(20, 16'h100);
    smp_tap = 5'd8;  send_clean(20, 16'h200);
    smp_tap = 5'd31; send_clean(40, 16'h300);
    smp_tap = 5'd0;  send_clean(20, 16'h400);

    // R6: back-pressure
    tag = "R6";
    for (int n = 0; n < 30; n++) begin
      iq_ready = (n % 3) != 0;
      send(1'b1, 16'(16'hB000 + n), 1'b0, 16'(16'hC000 + n));
    end
    iq_ready = 1'b0;
    send_clean(5, 16'h600);
    iq_ready = 1'b1;
    send_clean(5, 16'h700);

    // R4: broken order: orphan Q, doubled I
    tag = "R4";
    for (int n = 0; n < 24; n++) begin
      case (n % 4)
        0: send(1'b0, 16'(16'h1100 + n), 1'b0, 16'(16'h2200 + n));
        1: send(1'b1, 16'(16'h3300 + n), 1'b1, 16'(16'h4400 + n));
        2: send(1'b0, 16'(16'h5500 + n), 1'b1, 16'(16'h6600 + n));
        default: send(1'b0, 16'(16'h7700 + n), 1'b0, 16'(16'h8800 + n));
      endcase
    end
    send_clean(10, 16'h800);

    // R7: probe placement sweep
    tag = "R7";
    setup_tap = 5'd4;  hold_tap = 5'd4;  send_clean(8, 16'h900);
    setup_tap = 5'd5;  hold_tap = 5'd0;  send_clean(8, 16'h910);
    setup_tap = 5'd0;  hold_tap = 5'd31; send_clean(8, 16'h920);
    setup_tap = 5'd31; hold_tap = 5'd0;  send_clean(8, 16'h930);
    setup_tap = 5'd2;  hold_tap = 5'd7;  send_clean(8, 16'h940);
    setup_tap = 5'd0;  hold_tap = 5'd0;  send_clean(8, 16'h950);

    // R8: single strobe glitch travelling to the probe
    tag = "R8";
    send_clean(5, 16'hA00);
    send(1'b0, 16'hDEAD, 1'b0, 16'hBEEF);
    send_clean(40, 16'hA10);

    finish_run();
  end

endmodule